// File: doc/BRIEF.md
# Sub-Aperture Row Readout Sequencer

This block paces the readout of an imaging array one row of sub-apertures at a time. Each sub-aperture is a square tile of 20 pixel rows. A free-running period timer divides every read period into one conversion slot per pixel row. It issues a convert strobe at the start of each slot and a transfer strobe on the final cycle of the period, which hands the converted data to the serializer.

While one row is being read, a host uses a mode-0 SPI link to upload the settings for the next read. These are the sub-aperture row address, a set of option bits and a 2-bit gain code for every sub-aperture across the row. A frame that arrives complete and valid is held in a shadow copy, and a ready flag tells the host that it is waiting. The shadow copy becomes the active setting that drives the row select and the gain selects only at a period boundary. The host can therefore visit rows in any order and change every gain on every read without stalling the readout. When no upload is pending, the active options decide whether the row address steps forward and wraps, or stays where it is.

Top module: `subap_read_seq`

## Requirements
- R1: After reset the active row is 0, all gain codes and option bits are 0, the ready flag is low, and the timer is at the first cycle of a period (period start, convert strobe, pixel row 0).
- R2: An SPI frame is sampled on rising SCLK while chip select is low, MSB first. It holds the row address (ROW_W bits), then the option bits (OPT_W bits), then one 2-bit gain code per sub-aperture starting from sub-aperture 0. Gain code 0,1,2,3 means x1,x2,x4,x8, and sub-aperture i drives gain_sel[2i+1:2i].
- R3: A frame is accepted only when chip select rises after exactly FRAME_W bits and the row address is below N_ROWS. Acceptance raises the ready flag. Any other frame is discarded and leaves the flag and the shadow unchanged.
- R4: Accepted settings stay invisible on the outputs until the first cycle of the next period. In that cycle they appear together and the ready flag falls.
- R5: If chip select is low at a period boundary, the active gains and options are kept. A complete frame that is still waiting loads at the first later boundary where the link is idle.
- R6: With option bit 0 set and no frame waiting, the row address rises by one each period and wraps from N_ROWS-1 to 0. Gains and options are kept.
- R7: With option bit 0 clear and no frame waiting, the row address is held.
- R8: A period lasts SLOT_CYCLES*PIX_ROWS cycles. The convert strobe pulses once at the start of each of the PIX_ROWS slots, with pix_row giving the slot index. The transfer strobe pulses only on the last cycle of the period, and the period-start flag pulses only on the first.
- R9: An uploaded row address is loaded whatever the current row is, and it takes precedence over the sequential step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data in |
| row_addr | output | ROW_W | Active sub-aperture row |
| gain_sel | output | 2*N_SUBAP | Active gain code per sub-aperture |
| opt_bits | output | OPT_W | Active option bits |
| cfg_ready | output | 1 | A valid frame waits for the next boundary |
| period_start | output | 1 | First cycle of a read period |
| conv_strobe | output | 1 | Start of a pixel-row conversion slot |
| pix_row | output | PIX_W | Pixel row index within the tile |
| xfer_strobe | output | 1 | Last cycle of the period; converted data moves to the serializer |

## Verification
The SPI inputs pass through a two-stage synchronizer and an edge detector, so the ready flag rises about three clock cycles after chip select rises. The bench waits six cycles after the end of each frame before it samples the flag. Active settings change on the clock edge that begins a period. The bench finds that cycle by watching period_start at the falling edge, and checks the row, gains and options in that same cycle. The timer outputs are purely a function of the period counter, so the bench checks every cycle of a whole period against the cycle index, counted from the observed period start.

// File: rtl/subap_seq_pkg.sv
package subap_seq_pkg;
  typedef enum logic [1:0] {
    GAIN_X1 = 2'd0,
    GAIN_X2 = 2'd1,
    GAIN_X4 = 2'd2,
    GAIN_X8 = 2'd3
  } gain_code_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/spi_shadow_rx.sv
module spi_shadow_rx #(
  parameter int unsigned ROW_W   = 3,
  parameter int unsigned OPT_W   = 4,
  parameter int unsigned N_SUBAP = 4,
  parameter int unsigned N_ROWS  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   mosi,
  input  logic                   take,
  output logic                   busy,
  output logic                   pending,
  output logic [ROW_W-1:0]       sh_row,
  output logic [OPT_W-1:0]       sh_opt,
  output logic [2*N_SUBAP-1:0]   sh_gain
);
  import subap_seq_pkg::*;

  localparam int unsigned FRAME_W = ROW_W + OPT_W + 2*N_SUBAP;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam int unsigned GAIN_TOP = FRAME_W - ROW_W - OPT_W;

  logic [SYNC_DEPTH:0]   sclk_q, cs_q;
  logic [SYNC_DEPTH-1:0] mosi_q;
  logic                  sclk_rise, cs_end;

  logic [FRAME_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               pend_n;
  logic               frame_ok;
  logic [ROW_W-1:0]       f_row;
  logic [OPT_W-1:0]       f_opt;
  logic [2*N_SUBAP-1:0]   f_gain;

  // synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_DEPTH-1:0], sclk};
      cs_q   <= {cs_q[SYNC_DEPTH-1:0], cs_n};
      mosi_q <= {mosi_q[SYNC_DEPTH-2:0], mosi};
    end
  end

  assign sclk_rise = sclk_q[SYNC_DEPTH-1] & ~sclk_q[SYNC_DEPTH];
  assign cs_end    = cs_q[SYNC_DEPTH-1] & ~cs_q[SYNC_DEPTH];
  assign busy      = ~cs_q[SYNC_DEPTH-1];

  // frame field split
  assign f_row = shift_q[FRAME_W-1 -: ROW_W];
  assign f_opt = shift_q[FRAME_W-ROW_W-1 -: OPT_W];
  for (genvar i = 0; i < N_SUBAP; i++) begin : g_field
    assign f_gain[2*i +: 2] = shift_q[GAIN_TOP-2*(i+1) +: 2];
  end

  assign frame_ok = cs_end && (cnt_q == CNT_W'(FRAME_W)) &&
                    ({1'b0, f_row} < (ROW_W+1)'(N_ROWS));

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    if (!busy) begin
      cnt_n = '0;
    end else if (sclk_rise) begin
      shift_n = {shift_q[FRAME_W-2:0], mosi_q[SYNC_DEPTH-1]};
      if (cnt_q != CNT_W'(FRAME_W + 1)) cnt_n = cnt_q + 1'b1;
    end
    pend_n = pending;
    if (frame_ok)  pend_n = 1'b1;
    else if (take) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      pending <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_row  <= '0;
      sh_opt  <= '0;
      sh_gain <= '0;
    end else if (frame_ok) begin
      sh_row  <= f_row;
      sh_opt  <= f_opt;
      sh_gain <= f_gain;
    end
  end

  assert_ready_rises_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> !busy);
  assert_shadow_stable_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sh_gain) && $stable(sh_row));
endmodule

// File: rtl/read_period_timer.sv
module read_period_timer #(
  parameter int unsigned SLOT_CYCLES = 8,
  parameter int unsigned PIX_ROWS    = 20,
  parameter int unsigned PIX_W       = $clog2(PIX_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             period_start,
  output logic             conv_strobe,
  output logic             xfer_strobe,
  output logic [PIX_W-1:0] pix_row
);
  localparam int unsigned SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [PIX_W-1:0]  pix_q, pix_n;
  logic              slot_last, pix_last;

  assign slot_last = (slot_q == SLOT_W'(SLOT_CYCLES - 1));
  assign pix_last  = (pix_q == PIX_W'(PIX_ROWS - 1));

  always_comb begin
    slot_n = slot_q + 1'b1;
    pix_n  = pix_q;
    if (slot_last) begin
      slot_n = '0;
      pix_n  = pix_last ? '0 : pix_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pix_q  <= '0;
    end else begin
      slot_q <= slot_n;
      pix_q  <= pix_n;
    end
  end

  assign conv_strobe  = (slot_q == '0);
  assign period_start = conv_strobe && (pix_q == '0);
  assign xfer_strobe  = slot_last && pix_last;
  assign pix_row      = pix_q;

  assert_xfer_then_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |=> period_start);
  assert_start_has_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> conv_strobe && !xfer_strobe);
endmodule

// File: rtl/active_cfg.sv
module active_cfg #(
  parameter int unsigned ROW_W   = 3,
  parameter int unsigned OPT_W   = 4,
  parameter int unsigned N_SUBAP = 4,
  parameter int unsigned N_ROWS  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boundary,
  input  logic                 pending,
  input  logic                 busy,
  input  logic [ROW_W-1:0]     sh_row,
  input  logic [OPT_W-1:0]     sh_opt,
  input  logic [2*N_SUBAP-1:0] sh_gain,
  output logic                 take,
  output logic [ROW_W-1:0]     row_q,
  output logic [OPT_W-1:0]     opt_q,
  output logic [2*N_SUBAP-1:0] gain_q
);
  logic [ROW_W-1:0]     row_n;
  logic [OPT_W-1:0]     opt_n;
  logic [2*N_SUBAP-1:0] gain_n;
  logic                 advance;

  assign take    = boundary && pending && !busy;
  assign advance = boundary && !take && opt_q[0];

  always_comb begin
    row_n  = row_q;
    opt_n  = opt_q;
    gain_n = gain_q;
    if (take) begin
      row_n  = sh_row;
      opt_n  = sh_opt;
      gain_n = sh_gain;
    end else if (advance) begin
      row_n = (row_q == ROW_W'(N_ROWS - 1)) ? '0 : row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      opt_q  <= '0;
      gain_q <= '0;
    end else if (boundary) begin
      row_q  <= row_n;
      opt_q  <= opt_n;
      gain_q <= gain_n;
    end
  end

  assert_change_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(row_q) && $stable(opt_q) && $stable(gain_q));
  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && busy) |=> $stable(opt_q) && $stable(gain_q));
  assert_row_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, row_q} < (ROW_W+1)'(N_ROWS));
endmodule

// File: rtl/subap_read_seq.sv
module subap_read_seq #(
  parameter int unsigned N_ROWS      = 6,
  parameter int unsigned N_SUBAP     = 4,
  parameter int unsigned OPT_W       = 4,
  parameter int unsigned SLOT_CYCLES = 8,
  parameter int unsigned PIX_ROWS    = 20,
  parameter int unsigned ROW_W       = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  parameter int unsigned PIX_W       = $clog2(PIX_ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic [ROW_W-1:0]     row_addr,
  output logic [2*N_SUBAP-1:0] gain_sel,
  output logic [OPT_W-1:0]     opt_bits,
  output logic                 cfg_ready,
  output logic                 period_start,
  output logic                 conv_strobe,
  output logic [PIX_W-1:0]     pix_row,
  output logic                 xfer_strobe
);
  logic                 take, busy, pending;
  logic [ROW_W-1:0]     sh_row;
  logic [OPT_W-1:0]     sh_opt;
  logic [2*N_SUBAP-1:0] sh_gain;

  spi_shadow_rx #(
    .ROW_W(ROW_W), .OPT_W(OPT_W), .N_SUBAP(N_SUBAP), .N_ROWS(N_ROWS)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .take(take), .busy(busy), .pending(pending),
    .sh_row(sh_row), .sh_opt(sh_opt), .sh_gain(sh_gain)
  );

  read_period_timer #(
    .SLOT_CYCLES(SLOT_CYCLES), .PIX_ROWS(PIX_ROWS), .PIX_W(PIX_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .period_start(period_start),
    .conv_strobe(conv_strobe), .xfer_strobe(xfer_strobe), .pix_row(pix_row)
  );

  active_cfg #(
    .ROW_W(ROW_W), .OPT_W(OPT_W), .N_SUBAP(N_SUBAP), .N_ROWS(N_ROWS)
  ) u_act (
    .clk(clk), .rst_n(rst_n), .boundary(xfer_strobe), .pending(pending), .busy(busy),
    .sh_row(sh_row), .sh_opt(sh_opt), .sh_gain(sh_gain), .take(take),
    .row_q(row_addr), .opt_q(opt_bits), .gain_q(gain_sel)
  );

  assign cfg_ready = pending;

  assert_ready_clears_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_strobe && cfg_ready && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) &&
     $past(cfg_ready)) |=> !cfg_ready);
endmodule

// File: tb/sim_subap_read_seq.sv
`timescale 1ns/1ps
module sim_subap_read_seq;
  localparam int NR = 6, NS = 4, OW = 4, SC = 8, PR = 20;
  localparam int RW = 3, PW = 5;
  localparam int FW = RW + OW + 2*NS;
  localparam int PER = SC * PR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [RW-1:0] row_addr;
  logic [2*NS-1:0] gain_sel;
  logic [OW-1:0] opt_bits;
  logic cfg_ready, period_start, conv_strobe, xfer_strobe;
  logic [PW-1:0] pix_row;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  subap_read_seq #(.N_ROWS(NR), .N_SUBAP(NS), .OPT_W(OW), .SLOT_CYCLES(SC), .PIX_ROWS(PR)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .row_addr(row_addr), .gain_sel(gain_sel), .opt_bits(opt_bits), .cfg_ready(cfg_ready),
    .period_start(period_start), .conv_strobe(conv_strobe), .pix_row(pix_row),
    .xfer_strobe(xfer_strobe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gvec(input int s);
    logic [7:0] v;
    for (int i = 0; i < NS; i++) v[2*i +: 2] = 2'((s + i) % 4);
    return v;
  endfunction

  function automatic logic [31:0] mkframe(input int r, input int o, input logic [7:0] g);
    logic [31:0] f;
    f = 32'(r);
    f = (f << OW) | 32'(o);
    for (int i = 0; i < NS; i++) f = (f << 2) | 32'(g[2*i +: 2]);
    return f;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_send(input logic [31:0] f, input int nb);
    cs_n = 1'b0;
    cyc(4);
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = f[i];
      cyc(2);
      sclk = 1'b1;
      cyc(2);
      sclk = 1'b0;
    end
    cyc(2);
    cs_n = 1'b1;
    cyc(6);
  endtask

  task automatic wait_ps();
    do @(negedge clk); while (!period_start);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int convs, badpix, badx;
    logic [7:0] g;
    int r;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (first cycle after release still shows counter at 0 only if timer idle; check after reset in cycle 0)
    chk("R1 row", 32'(row_addr), 0);
    chk("R1 gain", 32'(gain_sel), 0);
    chk("R1 opt", 32'(opt_bits), 0);
    chk("R1 ready", 32'(cfg_ready), 0);

    // R8 timing over one full period
    wait_ps();
    chk("R8 conv at start", 32'(conv_strobe), 1);
    chk("R8 pix0", 32'(pix_row), 0);
    convs = 1; badpix = 0; badx = 0;
    for (int c = 1; c < PER; c++) begin
      @(negedge clk);
      if (conv_strobe) begin
        convs++;
        if (c % SC != 0 || int'(pix_row) != c / SC) badpix++;
      end
      if (xfer_strobe !== (c == PER - 1)) badx++;
      if (period_start) badx++;
    end
    chk("R8 conv count", 32'(convs), PR);
    chk("R8 pix index", 32'(badpix), 0);
    chk("R8 xfer/start placement", 32'(badx), 0);
    @(negedge clk);
    chk("R8 period length", 32'(period_start), 1);

    // R2/R4/R9 random row order with gain sweep
    r = 0;
    for (int k = 0; k < NR; k++) begin
      int nr, no;
      logic [RW-1:0] prev;
      nr = (k * 5 + 3) % NR;
      no = (k << 1) & 14;
      g = gvec(k);
      wait_ps();
      prev = row_addr;
      spi_send(mkframe(nr, no, g), FW);
      chk("R3 ready after frame", 32'(cfg_ready), 1);
      chk("R4 not early", 32'(row_addr), 32'(prev));
      wait_ps();
      chk("R9 row loaded", 32'(row_addr), 32'(nr));
      chk("R2 gains", 32'(gain_sel), 32'(g));
      chk("R2 opts", 32'(opt_bits), 32'(no));
      chk("R4 ready cleared", 32'(cfg_ready), 0);
    end
    // last load: k=5 -> row 4, opt bit0 clear, gains gvec(5)
    // R7 hold
    wait_ps(); wait_ps();
    chk("R7 row held", 32'(row_addr), 4);

    // R3 bad frames
    spi_send(mkframe(2, 0, 8'h55), FW - 1);
    chk("R3 short frame", 32'(cfg_ready), 0);
    spi_send(mkframe(7, 0, 8'h55), FW);
    chk("R3 bad row", 32'(cfg_ready), 0);
    spi_send({mkframe(2, 0, 8'h55), 1'b1}, FW + 1);
    chk("R3 long frame", 32'(cfg_ready), 0);
    wait_ps();
    chk("R3 row unchanged", 32'(row_addr), 4);
    chk("R3 gains unchanged", 32'(gain_sel), 32'(gvec(5)));

    // R5 transfer spanning boundary
    wait_ps();
    cyc(110);
    spi_send(mkframe(1, 0, 8'hC6), FW);
    chk("R5 ready pending", 32'(cfg_ready), 1);
    chk("R5 row kept", 32'(row_addr), 4);
    chk("R5 gains kept", 32'(gain_sel), 32'(gvec(5)));
    wait_ps();
    chk("R5 deferred load row", 32'(row_addr), 1);
    chk("R5 deferred load gains", 32'(gain_sel), 32'hC6);

    // R6 sequential advance with wrap
    wait_ps();
    spi_send(mkframe(4, 1, 8'h1B), FW);
    wait_ps();
    chk("R6 start row", 32'(row_addr), 4);
    for (int p = 1; p <= 3; p++) begin
      wait_ps();
      chk("R6 advance", 32'(row_addr), 32'((4 + p) % NR));
      chk("R6 gains kept", 32'(gain_sel), 32'h1B);
    end
    // row now 1; R9 upload overrides sequential step
    spi_send(mkframe(3, 1, 8'h27), FW);
    wait_ps();
    chk("R9 override advance", 32'(row_addr), 3);
    wait_ps();
    chk("R6 continue", 32'(row_addr), 4);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule